// File: doc/BRIEF.md
# Realignable Divided Output Clock

This block derives a slower output clock from a shared sampling clock. It divides by 2 in single data rate mode and by 4 in double data rate mode. Several copies of it can share one sampling clock. An alignment request pulse, which may rise at any moment, freezes every copy's output at an idle level. When the pulse is removed in step with the sampling clock, all copies restart their divider phase together. They then produce identical output clock edges from the first one onward.

The idle level is chosen from the rate mode and an edge-polarity select. After release, the output stays idle for a fixed number of sampling-clock cycles, set by a parameter. That number is the same clock-to-output delay the divider shows in steady running. A one-cycle strobe marks the first output edge after a restart.

Alignment must not disturb an on-going calibration. A request that arrives while calibration is busy is refused. It leaves the divider running and raises a sticky error flag. The next request made while calibration is idle is honoured and clears that flag. A synchronous reset behaves like an alignment request that is released when the reset goes low.

Top module: `dclk_align_div`

## Requirements
- R1: Raising `align_req` while `cal_busy` is low forces `dclk` to the idle level at once, within the same sampling-clock cycle and before the next rising edge. A truncated output pulse at that moment is allowed.
- R2: The idle level is 0 when `ddr_mode`=1. When `ddr_mode`=0, the idle level equals `edge_sel` (0 gives low, 1 gives high). `dclk` holds this level for as long as the request stays high.
- R3: Release is taken at the first rising edge of `clk` that sees `align_req` low. Call that edge E0. `dclk` stays at the idle level through edges E1 to E(LAT-1). It first leaves the idle level at edge E(LAT), where LAT is `RESTART_LAT` (default 2).
- R4: With `ddr_mode`=0, from edge E(LAT) onward `dclk` toggles on every rising edge of `clk`, giving a period of 2 sampling-clock cycles.
- R5: With `ddr_mode`=1, from edge E(LAT) onward `dclk` toggles on every second rising edge of `clk`, giving a period of 4 sampling-clock cycles.
- R6: `align_done` is high for exactly one cycle, after edge E(LAT), together with the first output change. It is low at all other times.
- R7: While `cal_busy` is high, `align_req` has no effect on `dclk`, which keeps toggling. At the next rising edge, `cal_err` is set.
- R8: `cal_err` stays high until a rising edge sees `align_req` high with `cal_busy` low. That edge clears it.
- R9: Two instances that get the same release edge produce identical `dclk` and `align_done` from E0 onward, whenever each one's request was raised.
- R10: While `rst` is high, `dclk` is at the idle level, and `align_done` and `cal_err` are 0. The edge after `rst` falls acts as a release edge E0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| align_req | input | 1 | Alignment request, asynchronous rise, release sampled on rising clk |
| ddr_mode | input | 1 | 0 = single data rate (divide by 2), 1 = double data rate (divide by 4) |
| edge_sel | input | 1 | Output edge select; sets the idle level in single data rate mode |
| cal_busy | input | 1 | High while calibration runs; alignment is refused |
| dclk | output | 1 | Divided output clock |
| align_done | output | 1 | One-cycle strobe on the first output edge after restart |
| cal_err | output | 1 | Sticky flag for a request refused during calibration |

## Verification
The bench drives two instances whose requests rise at different sub-cycle offsets and in different cycles, then releases both together. A divider that kept phase across the hold, or restarted from the request edge, would show mismatched `dclk` traces. Each of the four mode and edge combinations is checked for its idle level and for the exact edge where toggling resumes. An off-by-one in the restart counter would move the first edge and the `align_done` strobe. A test raises the request mid-cycle and samples before the next rising edge, which exposes a design that only enters hold synchronously. The calibration tests check that a refused request leaves the output toggling, that the error flag holds across idle cycles, and that it clears only on an accepted request.

// File: rtl/dclk_align_pkg.sv
package dclk_align_pkg;

    typedef enum logic {
        RATE_SDR = 1'b0,
        RATE_DDR = 1'b1
    } rate_e;

    typedef struct packed {
        rate_e rate;
        logic  edge_hi;
    } dclk_cfg_t;

    // Level the output rests at while an alignment hold is active.
    function automatic logic idle_level(input dclk_cfg_t cfg);
        return (cfg.rate == RATE_DDR) ? 1'b0 : cfg.edge_hi;
    endfunction

    // True on the cycle where the divider output must flip.
    function automatic logic phase_wrap(input dclk_cfg_t cfg, input logic ph);
        return (cfg.rate == RATE_SDR) ? 1'b1 : ph;
    endfunction

endpackage

// File: rtl/dclk_align_ctrl.sv
module dclk_align_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic align_req,
    input  logic cal_busy,
    output logic hold_q,
    output logic cal_err_q
);
    logic req_gate;

    // A request is only accepted while calibration is idle.
    assign req_gate = align_req & ~cal_busy;

    // Entry into hold is asynchronous; exit happens on a rising clock edge.
    always_ff @(posedge clk or posedge req_gate) begin
        if (req_gate) begin
            hold_q <= 1'b1;
        end else if (rst) begin
            hold_q <= 1'b1;
        end else begin
            hold_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_err_q <= 1'b0;
        end else if (align_req) begin
            cal_err_q <= cal_busy;
        end
    end
endmodule

// File: rtl/dclk_restart_timer.sv
module dclk_restart_timer #(
    parameter int RESTART_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_q,
    output logic start,
    output logic running_q,
    output logic done_q
);
    localparam int CW = $clog2(RESTART_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(RESTART_LAT - 1);

    logic [CW-1:0] cnt_q;

    assign start = ~hold_q & ~running_q & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold_q) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (!running_q) begin
            if (cnt_q == LAST) begin
                running_q <= 1'b1;
                done_q    <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CW'(1);
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dclk_phase_gen.sv
module dclk_phase_gen
    import dclk_align_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold_q,
    input  logic      start,
    input  logic      running_q,
    input  dclk_cfg_t cfg,
    output logic      div_q
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst || hold_q) begin
            div_q <= idle_level(cfg);
            ph_q  <= 1'b0;
        end else if (start) begin
            div_q <= ~div_q;
            ph_q  <= 1'b0;
        end else if (running_q) begin
            if (phase_wrap(cfg, ph_q)) begin
                div_q <= ~div_q;
                ph_q  <= 1'b0;
            end else begin
                ph_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dclk_align_div.sv
module dclk_align_div
    import dclk_align_pkg::*;
#(
    parameter int RESTART_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic align_req,
    input  logic ddr_mode,
    input  logic edge_sel,
    input  logic cal_busy,
    output logic dclk,
    output logic align_done,
    output logic cal_err
);
    dclk_cfg_t cfg;
    logic      hold_q;
    logic      start;
    logic      running_q;
    logic      div_q;

    assign cfg = '{rate: rate_e'(ddr_mode), edge_hi: edge_sel};

    dclk_align_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .align_req (align_req),
        .cal_busy  (cal_busy),
        .hold_q    (hold_q),
        .cal_err_q (cal_err)
    );

    dclk_restart_timer #(.RESTART_LAT(RESTART_LAT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hold_q    (hold_q),
        .start     (start),
        .running_q (running_q),
        .done_q    (align_done)
    );

    dclk_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .hold_q    (hold_q),
        .start     (start),
        .running_q (running_q),
        .cfg       (cfg),
        .div_q     (div_q)
    );

    // Hold forces the idle level immediately, even mid-cycle.
    assign dclk = hold_q ? idle_level(cfg) : div_q;
endmodule

// File: rtl/dclk_align_div_chk.sv
module dclk_align_div_chk (
    input logic clk,
    input logic rst,
    input logic align_req,
    input logic ddr_mode,
    input logic edge_sel,
    input logic cal_busy,
    input logic dclk,
    input logic align_done,
    input logic cal_err
);
    logic exp_idle;
    assign exp_idle = ddr_mode ? 1'b0 : edge_sel;

    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        (align_req && !cal_busy) |-> (dclk == exp_idle));

    a_r3_no_done_in_hold: assert property (@(posedge clk) disable iff (rst)
        (align_req && !cal_busy) |=> !align_done);

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        align_done |=> !align_done);

    a_r6_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        align_done |-> (dclk != exp_idle));

    a_r7_err_set: assert property (@(posedge clk) disable iff (rst)
        (align_req && cal_busy) |=> cal_err);

    a_r8_err_clear: assert property (@(posedge clk) disable iff (rst)
        (align_req && !cal_busy) |=> !cal_err);
endmodule

bind dclk_align_div dclk_align_div_chk u_chk (.*);

// File: tb/dclk_align_div_tb.sv
module dclk_align_div_tb;
    localparam int LAT = 2;
    localparam int NVEC = 4;
    // Each entry: {ddr_mode, edge_sel, expected idle level}
    localparam logic [2:0] VEC [NVEC] = '{3'b000, 3'b011, 3'b100, 3'b110};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_a = 1'b0;
    logic req_b = 1'b0;
    logic ddr_mode = 1'b0;
    logic edge_sel = 1'b0;
    logic cal_busy = 1'b0;
    logic dclk_a, done_a, err_a;
    logic dclk_b, done_b, err_b;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dclk_align_div #(.RESTART_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .align_req(req_a), .ddr_mode(ddr_mode),
        .edge_sel(edge_sel), .cal_busy(cal_busy),
        .dclk(dclk_a), .align_done(done_a), .cal_err(err_a)
    );

    dclk_align_div #(.RESTART_LAT(LAT)) u_dut_b (
        .clk(clk), .rst(rst), .align_req(req_b), .ddr_mode(ddr_mode),
        .edge_sel(edge_sel), .cal_busy(cal_busy),
        .dclk(dclk_b), .align_done(done_b), .cal_err(err_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic exp_dclk(input logic ddr, input logic idle, input int k);
        if (k < LAT) return idle;
        if (!ddr) return idle ^ (((k - LAT) % 2) == 0);
        return idle ^ ((((k - LAT) / 2) % 2) == 0);
    endfunction

    // Sample k = 0 is the falling edge right after the release edge E0.
    task automatic check_restart(input string tag, input logic ddr, input logic idle, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({tag, " R3/R4/R5 dclk"}, dclk_a, exp_dclk(ddr, idle, k));
            chk({tag, " R6 align_done"}, done_a, (k == LAT));
            chk({tag, " R9 dclk match"}, dclk_b, dclk_a);
            chk({tag, " R9 done match"}, done_b, done_a);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic prev;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 dclk idle in reset", dclk_a, 1'b0);
        chk("R10 done low in reset", done_a, 1'b0);
        chk("R10 cal_err low in reset", err_a, 1'b0);
        rst = 1'b0;
        check_restart("R10 after reset", 1'b0, 1'b0, 8);

        // R1: mid-cycle assertion forces the idle level before the next edge
        @(negedge clk);
        if (dclk_a !== 1'b1) @(negedge clk);
        chk("R1 dclk high before request", dclk_a, 1'b1);
        #0.5 req_a = 1'b1;
        req_b = 1'b1;
        #0.5 chk("R1 async hold", dclk_a, 1'b0);
        @(negedge clk);
        req_a = 1'b0;
        req_b = 1'b0;
        check_restart("R1 restart", 1'b0, 1'b0, 6);

        // R2..R6, R9: table of mode settings
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            ddr_mode = VEC[v][2];
            edge_sel = VEC[v][1];
            #0.6 req_a = 1'b1;
            @(negedge clk);
            #1.9 req_b = 1'b1;
            repeat (2) @(negedge clk);
            chk("R2 idle level a", dclk_a, VEC[v][0]);
            chk("R2 idle level b", dclk_b, VEC[v][0]);
            chk("R2 no done in hold", done_a, 1'b0);
            req_a = 1'b0;
            req_b = 1'b0;
            check_restart("R2 table", VEC[v][2], VEC[v][0], 12);
        end

        // R7: request during calibration is refused
        @(negedge clk);
        ddr_mode = 1'b0;
        edge_sel = 1'b0;
        repeat (2) @(negedge clk);
        prev = dclk_a;
        cal_busy = 1'b1;
        req_a = 1'b1;
        req_b = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 keeps toggling", dclk_a, ~prev);
            chk("R7 no done", done_a, 1'b0);
            chk("R7 cal_err set", err_a, 1'b1);
            prev = dclk_a;
        end
        req_a = 1'b0;
        req_b = 1'b0;
        @(negedge clk);
        cal_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 cal_err sticky", err_a, 1'b1);
        chk("R8 cal_err sticky b", err_b, 1'b1);

        // R8: accepted request clears the flag
        req_a = 1'b1;
        req_b = 1'b1;
        @(negedge clk);
        chk("R8 cal_err cleared", err_a, 1'b0);
        chk("R8 hold after clear", dclk_a, 1'b0);
        req_a = 1'b0;
        req_b = 1'b0;
        check_restart("R8 restart", 1'b0, 1'b0, 6);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule